// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Byte Masking

This block is a single-port synchronous static RAM whose write data trails its address by one clock. On every rising edge it samples a chip select, a write enable, a per-byte write mask and an address. When that sample is a write, the data for it is taken from the write-data bus on the next rising edge, and the word is updated at that edge. A small pending-write buffer keeps the address and byte mask of the write in flight. The word is built from 9-bit bytes. The number of bytes is a parameter: two gives an 18-bit word and four gives a 36-bit word. Depth is also a parameter.

Reads are pipelined register to register. The array is read at the edge that samples the read. The result is merged byte by byte with any write data arriving at that same edge. It is then loaded into an output register on the following edge. An asynchronous output enable gates the data port, and a separate drive flag stands in for high impedance. A sleep input blocks new commands while keeping the contents. A write that was already sampled still completes.

A controller state machine tracks the pending write. Its states are:
- `ST_IDLE`: no write pending.
- `ST_PEND`: a write is waiting for its data at the next edge.
- `ST_SLEEP`: sleep is asserted.

Its transitions are taken at each rising edge:
- From any state, when sleep is high, go to `ST_SLEEP` (idle-to-sleep, pend-to-sleep, sleep-hold).
- Otherwise, an accepted write goes to `ST_PEND` (idle-to-pend, pend-to-pend for back-to-back writes, wake-to-pend).
- Otherwise, go to `ST_IDLE` (pend-commit-to-idle, wake-to-idle, idle-hold).

Top module: `lw_sram`

## Requirements
- R1: After reset, with `oe` high, `rdata` is all zeros and `rdata_drv` is 1.
- R2: A read (`sel`=1, `wr_en`=0, `sleep`=0) sampled at edge N puts the word on `rdata` after edge N+1. `rdata` then holds that word until a later read result replaces it.
- R3: A write sampled at edge N takes its data from `wdata` at edge N+1, and a later read of that address returns it.
- R4: Bit i of `byte_en` selects bits [9i+8:9i] of the word for update. Bytes whose bit is 0 keep their earlier contents.
- R5: A read sampled at the edge where a pending write's data arrives returns that data for the masked bytes and the array contents for the other bytes when the addresses match. For a different address it returns only the array contents.
- R6: Writes on consecutive cycles each commit one edge after their own address edge, so every one of them is stored.
- R7: With `sel`=0 a cycle starts no read and no write: memory contents and `rdata` are unchanged.
- R8: While `sleep` is 1, reads and writes sampled at that edge are ignored and contents are kept. A write sampled on the edge before sleep still commits its data.
- R9: When `oe` is 0, `rdata` is zero and `rdata_drv` is 0 without waiting for a clock edge. The output register keeps loading read results, so raising `oe` shows the most recent read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control and output state |
| sel | input | 1 | Synchronous chip select, active high |
| wr_en | input | 1 | 1 = write cycle, 0 = read cycle (when selected) |
| byte_en | input | NBYTES | Per-byte write mask; bit i covers bits [9i+8:9i] |
| addr | input | ADDR_W | Word address |
| wdata | input | NBYTES*BYTE_W | Write data, sampled one edge after its write command |
| sleep | input | 1 | Low-activity mode; blocks new commands |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | NBYTES*BYTE_W | Read data (zero when not driven) |
| rdata_drv | output | 1 | 1 when `rdata` is driven, 0 for high impedance |

## Verification
The bench reads an address on the cycle right after writing it. If forwarding were missing, that read would return stale array bytes. If the compare or the mask were wrong, bytes from a different address or outside the mask would leak into the result. It also issues back-to-back writes to the same and to different addresses; a buffer that let a new command overwrite the pending one before its commit would lose a word. The sleep cases check two things: a write sampled just before sleep must land, and commands sampled during sleep must have no effect, seen through reads after wake-up. The output-enable cases check that the data port goes to zero with no clock edge, and that a read made while it is off still becomes visible when it returns.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_SLEEP = 2'd2
    } lw_state_e;

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [NBYTES-1:0] byte_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sleep,
    output lw_state_e         state_q,
    output logic              wr_accept,
    output logic              rd_issue,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [NBYTES-1:0] commit_mask
);

    lw_state_e state_d;
    logic      cmd_live;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sleep)          state_d = ST_SLEEP;
                else if (wr_accept) state_d = ST_PEND;
                else                state_d = ST_IDLE;
            end
            ST_PEND: begin
                // the pending word commits at this edge whatever comes next
                if (sleep)          state_d = ST_SLEEP;
                else if (wr_accept) state_d = ST_PEND;
                else                state_d = ST_IDLE;
            end
            ST_SLEEP: begin
                if (sleep)          state_d = ST_SLEEP;
                else if (wr_accept) state_d = ST_PEND;
                else                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_live  = sel && !sleep;
        wr_accept = cmd_live && wr_en;
        rd_issue  = cmd_live && !wr_en;
        commit_en = (state_q == ST_PEND);
    end

    // pending-write buffer: address and mask wait for the trailing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_addr <= '0;
            commit_mask <= '0;
        end else if (wr_accept) begin
            commit_addr <= addr;
            commit_mask <= byte_en;
        end
    end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [NBYTES-1:0]        wmask,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic                     re,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [NBYTES*BYTE_W-1:0] rd_q
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];
        logic [BYTE_W-1:0] lane_q;

        // read returns the contents from before a same-edge write
        always_ff @(posedge clk) begin
            if (we && wmask[b]) begin
                lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
            end
            if (re) begin
                lane_q <= lane_mem[raddr];
            end
        end

        assign rd_q[b*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/lw_sram_out.sv
module lw_sram_out #(
    parameter int ADDR_W = 9,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_issue,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     commit_en,
    input  logic [ADDR_W-1:0]        commit_addr,
    input  logic [NBYTES-1:0]        commit_mask,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic [NBYTES*BYTE_W-1:0] arr_q,
    input  logic                     oe,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     rdata_drv,
    output logic [NBYTES*BYTE_W-1:0] out_q,
    output logic [NBYTES-1:0]        fwd_live
);

    localparam int W = NBYTES * BYTE_W;

    logic              rd_vld_q;
    logic [NBYTES-1:0] fwd_mask_q;
    logic [W-1:0]      fwd_data_q;
    logic [W-1:0]      merged;
    logic              addr_hit;

    assign addr_hit = commit_en && (commit_addr == rd_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q   <= 1'b0;
            fwd_mask_q <= '0;
            fwd_data_q <= '0;
            out_q      <= '0;
        end else begin
            rd_vld_q <= rd_issue;
            if (rd_issue) begin
                fwd_mask_q <= addr_hit ? commit_mask : '0;
                fwd_data_q <= wdata;
            end
            if (rd_vld_q) begin
                out_q <= merged;
            end
        end
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        assign merged[b*BYTE_W +: BYTE_W] = fwd_mask_q[b] ? fwd_data_q[b*BYTE_W +: BYTE_W]
                                                          : arr_q[b*BYTE_W +: BYTE_W];
    end

    assign fwd_live  = rd_vld_q ? fwd_mask_q : '0;
    assign rdata     = oe ? out_q : '0;
    assign rdata_drv = oe;

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel,
    input  logic                     wr_en,
    input  logic [NBYTES-1:0]        byte_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic                     sleep,
    input  logic                     oe,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     rdata_drv
);

    localparam int W = NBYTES * BYTE_W;

    lw_state_e         state_q;
    logic              wr_accept;
    logic              rd_issue;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [NBYTES-1:0] commit_mask;
    logic [W-1:0]      arr_q;
    logic [W-1:0]      out_q;
    logic [NBYTES-1:0] fwd_live;

    lw_sram_ctrl #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .wr_en       (wr_en),
        .byte_en     (byte_en),
        .addr        (addr),
        .sleep       (sleep),
        .state_q     (state_q),
        .wr_accept   (wr_accept),
        .rd_issue    (rd_issue),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_mask (commit_mask)
    );

    lw_sram_array #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) array_i (
        .clk   (clk),
        .we    (commit_en),
        .waddr (commit_addr),
        .wmask (commit_mask),
        .wdata (wdata),
        .re    (rd_issue),
        .raddr (addr),
        .rd_q  (arr_q)
    );

    lw_sram_out #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) out_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_issue    (rd_issue),
        .rd_addr     (addr),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_mask (commit_mask),
        .wdata       (wdata),
        .arr_q       (arr_q),
        .oe          (oe),
        .rdata       (rdata),
        .rdata_drv   (rdata_drv),
        .out_q       (out_q),
        .fwd_live    (fwd_live)
    );

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
    parameter int W      = 36,
    parameter int NBYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              oe,
    input logic [W-1:0]      rdata,
    input logic              rdata_drv,
    input logic              wr_accept,
    input logic              rd_issue,
    input logic              commit_en,
    input logic [W-1:0]      out_q,
    input logic [NBYTES-1:0] fwd_live
);

    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_accept, rd_issue})); // R2

    AST_COMMIT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> $past(wr_accept)); // R3

    AST_BACK_TO_BACK_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> commit_en); // R6

    AST_FWD_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_live != '0) |-> $past(commit_en)); // R5

    AST_SLEEP_NO_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!wr_accept && !rd_issue)); // R8

    AST_SLEEP_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> ##2 $stable(out_q)); // R8

    always_comb begin
        if (rst_n && (oe === 1'b0)) begin
            AST_OE_OFF_QUIET: assert ((rdata == '0) && !rdata_drv); // R9
        end
    end

endmodule

bind lw_sram lw_sram_chk #(
    .W      (W),
    .NBYTES (NBYTES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .oe        (oe),
    .rdata     (rdata),
    .rdata_drv (rdata_drv),
    .wr_accept (wr_accept),
    .rd_issue  (rd_issue),
    .commit_en (commit_en),
    .out_q     (out_q),
    .fwd_live  (fwd_live)
);

// File: tb/lw_sram_tb_top.sv
module lw_sram_tb_top;

    localparam int DEPTH  = 512;
    localparam int NB     = 4;
    localparam int BW     = 9;
    localparam int AW     = $clog2(DEPTH);
    localparam int W      = NB * BW;

    typedef struct {
        logic [W-1:0] d;
        string        tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel;
    logic          wr_en;
    logic [NB-1:0] byte_en;
    logic [AW-1:0] addr;
    logic [W-1:0]  wdata;
    logic          sleep;
    logic          oe;
    logic [W-1:0]  rdata;
    logic          rdata_drv;

    int n_chk  = 0;
    int n_fail = 0;

    exp_t          sb_q[$];
    logic [W-1:0]  model [DEPTH];
    logic          m_pend = 1'b0;
    logic [AW-1:0] m_addr;
    logic [NB-1:0] m_mask;
    logic          rd_now = 1'b0;
    logic          lat1 = 1'b0;
    logic          lat2 = 1'b0;

    always #5 clk = ~clk;

    lw_sram #(
        .DEPTH  (DEPTH),
        .NBYTES (NB),
        .BYTE_W (BW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr_en     (wr_en),
        .byte_en   (byte_en),
        .addr      (addr),
        .wdata     (wdata),
        .sleep     (sleep),
        .oe        (oe),
        .rdata     (rdata),
        .rdata_drv (rdata_drv)
    );

    function automatic logic [W-1:0] pat(input int i);
        return W'(36'h123456789) ^ W'(i * 36'h0F0F0F0F1);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one clock cycle of stimulus, model updated in protocol order
    task automatic cyc(input logic s, input logic we, input logic [NB-1:0] be,
                       input int a, input logic [W-1:0] wd, input logic slp,
                       input string tag);
        exp_t it;
        sel     = s;
        wr_en   = we;
        byte_en = be;
        addr    = AW'(a);
        wdata   = wd;
        sleep   = slp;
        if (m_pend) begin
            for (int b = 0; b < NB; b++) begin
                if (m_mask[b]) model[m_addr][b*BW +: BW] = wd[b*BW +: BW];
            end
            m_pend = 1'b0;
        end
        rd_now = s && !slp && !we;
        if (rd_now) begin
            it.d   = model[AW'(a)];
            it.tag = tag;
            sb_q.push_back(it);
        end
        if (s && !slp && we) begin
            m_pend = 1'b1;
            m_addr = AW'(a);
            m_mask = be;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 0, '0, 1'b0, "idle");
    endtask

    // monitor: a read sampled at edge N is compared after edge N+1
    always @(posedge clk) begin
        lat2 <= lat1;
        lat1 <= rd_now;
    end

    always @(negedge clk) begin
        if (lat2) begin
            if (sb_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R2: actual unexpected read result expected none");
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(it.tag, rdata, oe ? it.d : '0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        rst_n = 1'b0; sel = 1'b0; wr_en = 1'b0; byte_en = '0; addr = '0;
        wdata = '0; sleep = 1'b0; oe = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", rdata, '0);
        check("R1 drv", W'(rdata_drv), W'(1));

        // R3: full-word fill of addresses 0..7, data trails by one cycle
        for (int i = 0; i < 9; i++) begin
            cyc(i < 8, 1'b1, '1, i, (i > 0) ? pat(i - 1) : '0, 1'b0, "R3");
        end
        // R2/R3: back-to-back reads
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, '0, i, '0, 1'b0, "R3 readback");
        idle(4);
        check("R2 hold", rdata, pat(7));

        // R4: partial byte masks
        cyc(1'b1, 1'b1, 4'b0101, 2, '0, 1'b0, "R4");
        cyc(1'b0, 1'b0, '0, 0, 36'hAAAAAAAAA, 1'b0, "R4");
        cyc(1'b1, 1'b1, 4'b1000, 1, '0, 1'b0, "R4");
        cyc(1'b0, 1'b0, '0, 0, 36'h555555555, 1'b0, "R4");
        cyc(1'b1, 1'b0, '0, 2, '0, 1'b0, "R4 mask 0101");
        cyc(1'b1, 1'b0, '0, 1, '0, 1'b0, "R4 mask 1000");
        idle(2);

        // R5: read in the cycle the pending data arrives
        cyc(1'b1, 1'b1, 4'b0110, 3, '0, 1'b0, "R5");
        cyc(1'b1, 1'b0, '0, 3, 36'hFEDCBA987, 1'b0, "R5 forward hit");
        cyc(1'b1, 1'b1, 4'b1111, 4, '0, 1'b0, "R5");
        cyc(1'b1, 1'b0, '0, 5, 36'h0C0FFEE11, 1'b0, "R5 forward miss");
        cyc(1'b1, 1'b0, '0, 4, '0, 1'b0, "R5 committed");
        cyc(1'b1, 1'b0, '0, 3, '0, 1'b0, "R5 committed merge");
        idle(2);

        // R6: consecutive writes, including same address twice
        cyc(1'b1, 1'b1, '1, 5, '0, 1'b0, "R6");
        cyc(1'b1, 1'b1, '1, 6, 36'h111111111, 1'b0, "R6");
        cyc(1'b1, 1'b1, 4'b0011, 6, 36'h222222222, 1'b0, "R6");
        cyc(1'b1, 1'b0, '0, 6, 36'h333333333, 1'b0, "R6 double write fwd");
        cyc(1'b1, 1'b0, '0, 5, '0, 1'b0, "R6 first write");
        cyc(1'b1, 1'b0, '0, 6, '0, 1'b0, "R6 second pair");
        idle(2);

        // R7: deselected cycles do nothing
        cyc(1'b0, 1'b1, '1, 1, '0, 1'b0, "R7");
        cyc(1'b0, 1'b0, '0, 2, 36'h0BADBADBA, 1'b0, "R7");
        idle(2);
        check("R7 output unchanged", rdata, model[6]);
        cyc(1'b1, 1'b0, '0, 1, '0, 1'b0, "R7 write ignored");
        idle(2);

        // R8: sleep keeps a sampled write, ignores new commands
        cyc(1'b1, 1'b1, '1, 7, '0, 1'b0, "R8");
        cyc(1'b1, 1'b1, '1, 0, 36'h777777777, 1'b1, "R8");
        cyc(1'b1, 1'b0, '0, 1, 36'h999999999, 1'b1, "R8");
        held = rdata;
        cyc(1'b1, 1'b0, '0, 2, '0, 1'b1, "R8");
        idle(2);
        check("R8 output held", rdata, held);
        cyc(1'b1, 1'b0, '0, 7, '0, 1'b0, "R8 pending completed");
        cyc(1'b1, 1'b0, '0, 0, '0, 1'b0, "R8 sleep write ignored");
        idle(2);

        // R9: asynchronous output enable
        #2;
        oe = 1'b0;
        #1;
        check("R9 rdata off", rdata, '0);
        check("R9 drv off", W'(rdata_drv), W'(0));
        @(negedge clk);
        cyc(1'b1, 1'b0, '0, 2, '0, 1'b0, "R9 read while off");
        idle(2);
        #2;
        oe = 1'b1;
        #1;
        check("R9 latest read shown", rdata, model[2]);
        check("R9 drv on", W'(rdata_drv), W'(1));
        @(negedge clk);
        idle(2);

        if (sb_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2: actual %0d results missing expected 0", sb_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule